// File: doc/BRIEF.md
# Phase-Driven Pipeline Depth Controller

This block chooses how deeply the core pipeline runs in the next program interval. Three unification degrees are available: U1 keeps all twenty stages at full clock rate. U2 merges stage pairs into ten stages at half rate. U4 merges groups of four into five stages at quarter rate. At the end of each interval the controller takes two inputs. One is a single-cycle strobe with a flag from the signature unit that says whether the working set moved to a new phase. The other is an energy-delay figure for the interval that just finished, where lower is better.

The controller is a three-state loop. While the program stays in one phase, it holds the chosen degree. When a phase change is seen, it drops to the normal pipeline and waits there until two consecutive intervals match again. It then spends one interval each on U1, U2 and U4 and records the figure from each one. After that sweep it settles on the degree with the smallest recorded figure. A phase change during the sweep aborts it. Each interval figure is filed under the degree that was active while it was measured.

Top module: `phase_depth_ctrl`

## Requirements
- R1: After reset, state_o reads 2'b00 (stable) and degree_o reads 2'b00 (U1).
- R2: While ivl_end_i is low, state_o and degree_o keep their values, whatever phase_chg_i and metric_i do.
- R3: On an interval end with phase_chg_i high, from any state, the next state is 2'b01 (unstable) and the degree is U1.
- R4: On an interval end in unstable with phase_chg_i low, the next state is 2'b10 (tuning) and the degree stays U1.
- R5: On an interval end in tuning with phase_chg_i low, the degree steps U1 (2'b00) to U2 (2'b01) and U2 to U4 (2'b10), and the state stays tuning.
- R6: On an interval end in tuning at U4 with phase_chg_i low, the state becomes stable. The degree becomes the one whose sweep interval gave the smallest metric_i. The figure presented at this same interval end counts as the U4 result.
- R7: When sweep results are equal, U1 is preferred over U2 and U4, and U2 is preferred over U4.
- R8: On an interval end in stable with phase_chg_i low, the state and degree are held.
- R9: degree_o never reads 2'b11 and state_o never reads 2'b11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ivl_end_i | input | 1 | Single-cycle strobe marking the end of an interval |
| phase_chg_i | input | 1 | Phase-change flag from the signature unit, valid with ivl_end_i |
| metric_i | input | MW | Energy-delay figure of the finished interval, valid with ivl_end_i |
| degree_o | output | 2 | Degree for the next interval: 00 U1, 01 U2, 10 U4 |
| state_o | output | 2 | Controller state: 00 stable, 01 unstable, 10 tuning |

## Verification
Two actions can happen on the same interval-end edge: the U4 result is written into the score bank, and the best degree is chosen from all three results. The bench sets this up with sweeps where the last (U4) figure is the smallest. In that case a wrong choice shows up as U1 or U2 instead of U4 on degree_o in the cycle after the strobe. Other sweeps end with tied figures, or are aborted by a phase change partway through. These check that the choice uses only the fresh figures and follows the tie order.

// File: rtl/pdc_pkg.sv
package pdc_pkg;

    typedef enum logic [1:0] {
        ST_STABLE   = 2'b00,
        ST_UNSTABLE = 2'b01,
        ST_TUNING   = 2'b10
    } pstate_e;

    typedef enum logic [1:0] {
        DEG_U1 = 2'b00,
        DEG_U2 = 2'b01,
        DEG_U4 = 2'b10
    } degree_e;

    localparam int NDEG = 3;

    typedef struct packed {
        pstate_e st;
        degree_e deg;
    } ctl_t;

endpackage

// File: rtl/pdc_score_bank.sv
module pdc_score_bank #(
    parameter int MW   = 16,
    parameter int NDEG = 3
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [1:0]                wr_deg,
    input  logic [MW-1:0]             wr_val,
    output logic [NDEG-1:0][MW-1:0]   view_o
);

    logic [NDEG-1:0][MW-1:0] slot_d;
    logic [NDEG-1:0][MW-1:0] slot_q;

    for (genvar g = 0; g < NDEG; g++) begin : g_slot
        always_comb begin
            slot_d[g] = slot_q[g];
            if (wr_en && wr_deg == 2'(g)) begin
                slot_d[g] = wr_val;
            end
        end
        // the viewer sees the figure being written this cycle
        assign view_o[g] = slot_d[g];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_q <= '0;
        end else begin
            slot_q <= slot_d;
        end
    end

endmodule

// File: rtl/pdc_best_pick.sv
module pdc_best_pick
    import pdc_pkg::*;
#(
    parameter int MW = 16
) (
    input  logic [NDEG-1:0][MW-1:0] score_i,
    output degree_e                 best_o
);

    logic u1_wins;
    logic u2_beats_u4;

    always_comb begin
        u1_wins     = (score_i[0] <= score_i[1]) && (score_i[0] <= score_i[2]);
        u2_beats_u4 = (score_i[1] <= score_i[2]);
        if (u1_wins) begin
            best_o = DEG_U1;
        end else if (u2_beats_u4) begin
            best_o = DEG_U2;
        end else begin
            best_o = DEG_U4;
        end
    end

endmodule

// File: rtl/phase_depth_ctrl.sv
module phase_depth_ctrl
    import pdc_pkg::*;
#(
    parameter int MW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ivl_end_i,
    input  logic          phase_chg_i,
    input  logic [MW-1:0] metric_i,
    output logic [1:0]    degree_o,
    output logic [1:0]    state_o
);

    ctl_t ctl_d;
    ctl_t ctl_q;

    logic [NDEG-1:0][MW-1:0] score_view;
    degree_e                 best_deg;

    pdc_score_bank #(.MW(MW), .NDEG(NDEG)) u_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (ivl_end_i),
        .wr_deg (ctl_q.deg),
        .wr_val (metric_i),
        .view_o (score_view)
    );

    pdc_best_pick #(.MW(MW)) u_pick (
        .score_i (score_view),
        .best_o  (best_deg)
    );

    always_comb begin
        ctl_d = ctl_q;
        if (ivl_end_i) begin
            if (phase_chg_i) begin
                ctl_d.st  = ST_UNSTABLE;
                ctl_d.deg = DEG_U1;
            end else begin
                unique case (ctl_q.st)
                    ST_STABLE: begin
                        ctl_d = ctl_q;
                    end
                    ST_UNSTABLE: begin
                        ctl_d.st  = ST_TUNING;
                        ctl_d.deg = DEG_U1;
                    end
                    ST_TUNING: begin
                        unique case (ctl_q.deg)
                            DEG_U1:  ctl_d.deg = DEG_U2;
                            DEG_U2:  ctl_d.deg = DEG_U4;
                            default: begin
                                ctl_d.st  = ST_STABLE;
                                ctl_d.deg = best_deg;
                            end
                        endcase
                    end
                    default: begin
                        ctl_d.st  = ST_STABLE;
                        ctl_d.deg = DEG_U1;
                    end
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '{st: ST_STABLE, deg: DEG_U1};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign degree_o = ctl_q.deg;
    assign state_o  = ctl_q.st;

endmodule

// File: rtl/pdc_chk.sv
module pdc_chk #(
    parameter int MW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          ivl_end_i,
    input logic          phase_chg_i,
    input logic [MW-1:0] metric_i,
    input logic [1:0]    degree_o,
    input logic [1:0]    state_o
);

    // R9
    degree_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        degree_o != 2'b11 && state_o != 2'b11);

    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ivl_end_i |=> $stable(state_o) && $stable(degree_o));

    // R3
    phase_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ivl_end_i && phase_chg_i |=> state_o == 2'b01 && degree_o == 2'b00);

    // R4
    settle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ivl_end_i && !phase_chg_i && state_o == 2'b01
        |=> state_o == 2'b10 && degree_o == 2'b00);

    // R5
    sweep_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ivl_end_i && !phase_chg_i && state_o == 2'b10 && degree_o == 2'b00
        |=> state_o == 2'b10 && degree_o == 2'b01);

    // R8
    stable_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ivl_end_i && !phase_chg_i && state_o == 2'b00
        |=> state_o == 2'b00 && $stable(degree_o));

    // R6
    sweep_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ivl_end_i && !phase_chg_i && state_o == 2'b10 && degree_o == 2'b10
        |=> state_o == 2'b00);

    logic unused_metric;
    assign unused_metric = ^metric_i;

endmodule

bind phase_depth_ctrl pdc_chk #(.MW(MW)) u_chk (.*);

// File: tb/sim_phase_depth_ctrl.sv
module sim_phase_depth_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int MW = 16;
    localparam int NVEC = 26;

    // {chg, metric[15:0], exp_state[1:0], exp_deg[1:0], req[4:0]}
    localparam logic [25:0] VEC [NVEC] = '{
        {1'b1, 16'd5,  2'b01, 2'b00, 5'd3},  // R3 stable -> unstable
        {1'b1, 16'd5,  2'b01, 2'b00, 5'd3},  // R3 stays unstable
        {1'b0, 16'd5,  2'b10, 2'b00, 5'd4},  // R4
        {1'b0, 16'd30, 2'b10, 2'b01, 5'd5},  // R5 U1 result 30
        {1'b0, 16'd20, 2'b10, 2'b10, 5'd5},  // R5 U2 result 20
        {1'b0, 16'd25, 2'b00, 2'b01, 5'd6},  // R6 U4 25 -> U2
        {1'b0, 16'd99, 2'b00, 2'b01, 5'd8},  // R8
        {1'b1, 16'd1,  2'b01, 2'b00, 5'd3},  // R3
        {1'b0, 16'd1,  2'b10, 2'b00, 5'd4},  // R4
        {1'b0, 16'd40, 2'b10, 2'b01, 5'd5},  // R5
        {1'b0, 16'd50, 2'b10, 2'b10, 5'd5},  // R5
        {1'b0, 16'd10, 2'b00, 2'b10, 5'd6},  // R6 same-edge U4 win
        {1'b0, 16'd0,  2'b00, 2'b10, 5'd8},  // R8
        {1'b1, 16'd0,  2'b01, 2'b00, 5'd3},  // R3
        {1'b0, 16'd0,  2'b10, 2'b00, 5'd4},  // R4
        {1'b0, 16'd7,  2'b10, 2'b01, 5'd5},  // R5
        {1'b1, 16'd1,  2'b01, 2'b00, 5'd3},  // R3 sweep aborted
        {1'b0, 16'd1,  2'b10, 2'b00, 5'd4},  // R4
        {1'b0, 16'd8,  2'b10, 2'b01, 5'd5},  // R5
        {1'b0, 16'd8,  2'b10, 2'b10, 5'd5},  // R5
        {1'b0, 16'd9,  2'b00, 2'b00, 5'd7},  // R7 tie U1/U2 -> U1
        {1'b1, 16'd0,  2'b01, 2'b00, 5'd3},  // R3
        {1'b0, 16'd0,  2'b10, 2'b00, 5'd4},  // R4
        {1'b0, 16'd9,  2'b10, 2'b01, 5'd5},  // R5
        {1'b0, 16'd3,  2'b10, 2'b10, 5'd5},  // R5
        {1'b0, 16'd3,  2'b00, 2'b01, 5'd7}   // R7 tie U2/U4 -> U2
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ivl_end_i = 1'b0;
    logic          phase_chg_i = 1'b0;
    logic [MW-1:0] metric_i = '0;
    logic [1:0]    degree_o;
    logic [1:0]    state_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    phase_depth_ctrl #(.MW(MW)) u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .ivl_end_i   (ivl_end_i),
        .phase_chg_i (phase_chg_i),
        .metric_i    (metric_i),
        .degree_o    (degree_o),
        .state_o     (state_o)
    );

    task automatic check(input int req, input logic [1:0] exp_st, input logic [1:0] exp_dg);
        checks++;
        if (state_o !== exp_st || degree_o !== exp_dg) begin
            errors++;
            $display("FAIL R%0d: state=%b degree=%b expected state=%b degree=%b",
                     req, state_o, degree_o, exp_st, exp_dg);
        end
        checks++;
        if (degree_o === 2'b11 || state_o === 2'b11) begin
            errors++;
            $display("FAIL R9: state=%b degree=%b expected no 11 code", state_o, degree_o);
        end
    endtask

    task automatic interval(input logic chg, input logic [MW-1:0] m);
        @(negedge clk);
        ivl_end_i   = 1'b1;
        phase_chg_i = chg;
        metric_i    = m;
        @(negedge clk);
        ivl_end_i   = 1'b0;
        phase_chg_i = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(1, 2'b00, 2'b00);  // R1 reset state

        for (int i = 0; i < NVEC; i++) begin
            interval(VEC[i][25], VEC[i][24:9]);
            check(int'(VEC[i][4:0]), VEC[i][8:7], VEC[i][6:5]);
        end

        // R2: inputs wiggle without a strobe; stable U2 must persist
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            phase_chg_i = k[0];
            metric_i    = 16'(k * 1000);
            @(negedge clk);
            check(2, 2'b00, 2'b01);
        end
        phase_chg_i = 1'b0;

        // R2 during tuning: degree must not advance without a strobe
        interval(1'b1, 16'd0);
        interval(1'b0, 16'd0);
        interval(1'b0, 16'd4);
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            phase_chg_i = ~k[0];
            @(negedge clk);
            check(2, 2'b10, 2'b01);
        end
        phase_chg_i = 1'b0;

        // R1 reset mid-sweep returns to stable U1
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(1, 2'b00, 2'b00);

        // R8 stable U1 held after reset
        interval(1'b0, 16'd77);
        check(8, 2'b00, 2'b00);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule